// File: doc/BRIEF.md
# Strobed PCM Serial Voice Port

This block moves voice samples between two serial PCM lanes and a parallel interface clocked by a free-running master clock. Each lane, R and S, has its own enable strobe. While a lane's strobe is high, an external bit clock shifts one received sample in on its falling edges and one transmit sample out on its rising edges. The bit clock may be stopped whenever no strobe is high. The length of a received word is taken from the number of bit-clock cycles inside the window: eight cycles carry a companded code and sixteen carry a two's complement linear sample.

Inside the block, companded codes use sign-magnitude coding. On the serial line they may instead use G.711 mu-law or A-law coding. A format select decides which coding the line uses, and the same recoding is applied in both directions. When a window closes, the received word is passed to the master clock domain, where a one-cycle valid pulse marks it. A window with an illegal length discards its word and sets a sticky error flag for that lane. The transmit word is taken from a holding register in the master domain. That register follows the parallel transmit input while the lane is idle, and it is copied into the shifter on the first rising bit-clock edge of a window.

Top module: `pcm_voice_port`

## Requirements
- R1: A window of exactly 8 bit-clock cycles delivers the received code, taken MSB first, in `rx_*_word[7:0]`. The upper byte is zero, `rx_*_len16` is 0, and `rx_*_valid` is high for one cycle.
- R2: A window of exactly 16 bit-clock cycles delivers the received 16-bit word, taken MSB first, with `rx_*_len16` set to 1.
- R3: If a window closes after any number of cycles other than 8 or 16, no valid pulse is produced. The lane's `ferr_*` flag is set and stays at 1 until reset, including through later good windows.
- R4: With `g711_sel`=0, companded codes pass unchanged. With `g711_sel`=1 and `alaw_sel`=0, the line code is the internal sign-magnitude code XOR 0x7F (internal +zero 0x80 is 0xFF on the line). With `alaw_sel`=1, the mask is 0x55 (internal +full scale 0xFF is 0xAA on the line, and +zero 0x80 is 0xD5). The same mask applies on receive and on transmit.
- R5: Linear 16-bit words are never recoded in either direction, whatever the setting of `g711_sel` and `alaw_sel`.
- R6: The serial output changes on rising bit-clock edges and sends its word MSB first, starting at the first rising edge of the window. With `tx_lin`=1 it sends `tx_*_word[15:0]`. With `tx_lin`=0 it sends the recoded `tx_*_word[7:0]` followed by zeros.
- R7: A serial output is 0 whenever its lane's strobe is low.
- R8: The valid pulse is high in the cycle that follows the third rising master-clock edge after the strobe falls.
- R9: Activity on one lane causes no valid pulse and no error on the other lane.
- R10: After reset, all valid outputs, received words, length flags, error flags and serial outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock, may stop between windows |
| ena_r | input | 1 | Window strobe of lane R |
| ena_s | input | 1 | Window strobe of lane S |
| rin | input | 1 | Serial receive data of lane R |
| sin | input | 1 | Serial receive data of lane S |
| rout | output | 1 | Serial transmit data of lane R |
| sout | output | 1 | Serial transmit data of lane S |
| tx_lin | input | 1 | 1: transmit 16-bit linear words, 0: 8-bit codes |
| g711_sel | input | 1 | 1: line uses G.711 coding for companded words |
| alaw_sel | input | 1 | Law select when G.711 coding is used: 0 mu-law, 1 A-law |
| tx_r_word | input | 16 | Transmit sample of lane R |
| tx_s_word | input | 16 | Transmit sample of lane S |
| rx_r_word | output | 16 | Received sample of lane R |
| rx_r_len16 | output | 1 | Lane R word was 16 bits long |
| rx_r_valid | output | 1 | One-cycle pulse: lane R word ready |
| rx_s_word | output | 16 | Received sample of lane S |
| rx_s_len16 | output | 1 | Lane S word was 16 bits long |
| rx_s_valid | output | 1 | One-cycle pulse: lane S word ready |
| ferr_r | output | 1 | Sticky framing error of lane R |
| ferr_s | output | 1 | Sticky framing error of lane S |

## Verification
A received word is due exactly three rising master-clock edges after the bench lowers the strobe. The bench keeps a per-lane counter of master edges since it closed the window, and the monitor checks that the counter reads 3 whenever it pops an expected item. Transmit bits become valid at a rising bit-clock edge, and the bench reads them half a bit period later, just before it drives the falling edge. Error flags and idle outputs are checked several master cycles after the window closes, once the synchroniser has settled.

// File: rtl/pcmport_pkg.sv
package pcmport_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 8;
  localparam int CNT_W  = 5;

  // XOR mask between internal sign-magnitude and line coding
  function automatic logic [CODE_W-1:0] law_mask(input logic g711, input logic alaw);
    if (!g711)     return 8'h00;
    else if (alaw) return 8'h55;
    else           return 8'h7F;
  endfunction

  // recoding is its own inverse, so one function serves both directions
  function automatic logic [CODE_W-1:0] recode(input logic [CODE_W-1:0] code,
                                               input logic g711, input logic alaw);
    return code ^ law_mask(g711, alaw);
  endfunction
endpackage

// File: rtl/pcm_strobe_sync.sv
module pcm_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic busy,
  output logic closed
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], strobe};
  end

  assign busy   = sync_q[1];
  assign closed = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcmport_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          strobe,
  input  logic          busy,
  input  logic [W-1:0]  tx_word,
  input  logic          tx_lin,
  input  logic          g711,
  input  logic          alaw,
  output logic          sdo,
  output logic [CW-1:0] edge_cnt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [W-1:0] hold_q;
  logic [W-1:0] shift_q;
  logic         win_rst_n;
  logic         first_edge;

  // master-domain holding register, follows the input while the lane is idle
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (!busy) begin
      if (tx_lin) hold_q <= tx_word;
      else        hold_q <= {recode(tx_word[CODE_W-1:0], g711, alaw), {(W-CODE_W){1'b0}}};
    end
  end

  assign win_rst_n  = strobe & rst_n;
  assign first_edge = (edge_cnt == '0);

  // bit-clock shifter, cleared whenever the window is closed
  always_ff @(posedge bclk or negedge win_rst_n) begin
    if (!win_rst_n) begin
      sdo      <= 1'b0;
      shift_q  <= '0;
      edge_cnt <= '0;
    end else begin
      if (first_edge) begin
        sdo     <= hold_q[W-1];
        shift_q <= {hold_q[W-2:0], 1'b0};
      end else begin
        sdo     <= shift_q[W-1];
        shift_q <= {shift_q[W-2:0], 1'b0};
      end
      if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assert_idle_low_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    !strobe |-> !sdo);

  assert_hold_frozen_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hold_q));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcmport_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          strobe,
  input  logic          sdi,
  input  logic [CW-1:0] edge_cnt,
  input  logic          closed,
  input  logic          g711,
  input  logic          alaw,
  output logic [W-1:0]  rx_word,
  output logic          rx_len16,
  output logic          rx_valid,
  output logic          frame_err
);
  logic [W-1:0]  shift_q;
  logic [CW-1:0] bits_q;
  logic          close_short;
  logic          close_long;
  logic          close_bad;

  // falling-edge capture; count mirrors the rising edges seen so far
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bits_q  <= '0;
    end else if (strobe) begin
      shift_q <= {shift_q[W-2:0], sdi};
      bits_q  <= edge_cnt;
    end
  end

  // shift_q and bits_q are quiet once the window has closed
  assign close_short = closed && (bits_q == CW'(CODE_W));
  assign close_long  = closed && (bits_q == CW'(W));
  assign close_bad   = closed && !close_short && !close_long;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word   <= '0;
      rx_len16  <= 1'b0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid <= close_short | close_long;
      if (close_short) begin
        rx_word  <= {{(W-CODE_W){1'b0}}, recode(shift_q[CODE_W-1:0], g711, alaw)};
        rx_len16 <= 1'b0;
      end else if (close_long) begin
        rx_word  <= shift_q;
        rx_len16 <= 1'b1;
      end
      if (close_bad) frame_err <= 1'b1;
    end
  end

  assert_err_sticky_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_err |=> frame_err);

  assert_bad_no_valid_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    close_bad |=> !rx_valid);

  assert_valid_pulse_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_short_upper_zero_R1: assert property (@(posedge mclk) disable iff (!rst_n)
    (rx_valid && !rx_len16) |-> (rx_word[W-1:CODE_W] == '0));

  assert_linear_raw_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    close_long |=> (rx_word == $past(shift_q)));
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcmport_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int CW    = CNT_W,
  parameter int LANES = 2
) (
  input  logic         mclk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         ena_r,
  input  logic         ena_s,
  input  logic         rin,
  input  logic         sin,
  output logic         rout,
  output logic         sout,
  input  logic         tx_lin,
  input  logic         g711_sel,
  input  logic         alaw_sel,
  input  logic [W-1:0] tx_r_word,
  input  logic [W-1:0] tx_s_word,
  output logic [W-1:0] rx_r_word,
  output logic         rx_r_len16,
  output logic         rx_r_valid,
  output logic [W-1:0] rx_s_word,
  output logic         rx_s_len16,
  output logic         rx_s_valid,
  output logic         ferr_r,
  output logic         ferr_s
);
  logic [LANES-1:0]        strobe_v, sdi_v, sdo_v, busy_v, closed_v;
  logic [LANES-1:0]        len_v, valid_v, err_v;
  logic [LANES-1:0][W-1:0] txw_v, rxw_v;
  logic [LANES-1:0][CW-1:0] cnt_v;

  assign strobe_v = {ena_s, ena_r};
  assign sdi_v    = {sin, rin};
  assign txw_v    = {tx_s_word, tx_r_word};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pcm_strobe_sync u_sync (
      .clk(mclk), .rst_n(rst_n), .strobe(strobe_v[g]),
      .busy(busy_v[g]), .closed(closed_v[g])
    );

    pcm_tx_lane #(.W(W), .CW(CW)) u_tx (
      .mclk(mclk), .rst_n(rst_n), .bclk(bclk), .strobe(strobe_v[g]),
      .busy(busy_v[g]), .tx_word(txw_v[g]), .tx_lin(tx_lin),
      .g711(g711_sel), .alaw(alaw_sel), .sdo(sdo_v[g]), .edge_cnt(cnt_v[g])
    );

    pcm_rx_lane #(.W(W), .CW(CW)) u_rx (
      .mclk(mclk), .rst_n(rst_n), .bclk(bclk), .strobe(strobe_v[g]),
      .sdi(sdi_v[g]), .edge_cnt(cnt_v[g]), .closed(closed_v[g]),
      .g711(g711_sel), .alaw(alaw_sel), .rx_word(rxw_v[g]),
      .rx_len16(len_v[g]), .rx_valid(valid_v[g]), .frame_err(err_v[g])
    );
  end

  assign rout       = sdo_v[0];
  assign sout       = sdo_v[1];
  assign rx_r_word  = rxw_v[0];
  assign rx_s_word  = rxw_v[1];
  assign rx_r_len16 = len_v[0];
  assign rx_s_len16 = len_v[1];
  assign rx_r_valid = valid_v[0];
  assign rx_s_valid = valid_v[1];
  assign ferr_r     = err_v[0];
  assign ferr_s     = err_v[1];
endmodule

// File: tb/sim_pcm_voice_port.sv
module sim_pcm_voice_port;
  localparam int CLK_PERIOD = 50;
  localparam int BHALF      = 150;

  logic mclk = 1'b0, rst_n = 1'b0, bclk = 1'b0;
  logic ena_r = 1'b0, ena_s = 1'b0, rin = 1'b0, sin = 1'b0;
  logic tx_lin = 1'b0, g711_sel = 1'b0, alaw_sel = 1'b0;
  logic [15:0] tx_r_word = '0, tx_s_word = '0;
  logic rout, sout, rx_r_len16, rx_r_valid, rx_s_len16, rx_s_valid, ferr_r, ferr_s;
  logic [15:0] rx_r_word, rx_s_word;

  int n_checks = 0, n_fail = 0;
  int age [2];
  int seen[2];
  logic [16:0] exp_q0[$];
  logic [16:0] exp_q1[$];

  pcm_voice_port u0 (
    .mclk(mclk), .rst_n(rst_n), .bclk(bclk), .ena_r(ena_r), .ena_s(ena_s),
    .rin(rin), .sin(sin), .rout(rout), .sout(sout), .tx_lin(tx_lin),
    .g711_sel(g711_sel), .alaw_sel(alaw_sel), .tx_r_word(tx_r_word),
    .tx_s_word(tx_s_word), .rx_r_word(rx_r_word), .rx_r_len16(rx_r_len16),
    .rx_r_valid(rx_r_valid), .rx_s_word(rx_s_word), .rx_s_len16(rx_s_len16),
    .rx_s_valid(rx_s_valid), .ferr_r(ferr_r), .ferr_s(ferr_s)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  always @(posedge mclk) begin
    age[0] <= age[0] + 1;
    age[1] <= age[1] + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line coding from the requirement table, written as a lookup by law
  function automatic logic [7:0] line_code(input logic [7:0] c, input logic g, input logic a);
    logic [7:0] m;
    case ({g, a})
      2'b10:   m = 8'h7F;
      2'b11:   m = 8'h55;
      default: m = 8'h00;
    endcase
    return m ^ c;
  endfunction

  // monitor: pops the scoreboard on every valid pulse
  always @(negedge mclk) begin
    if (rx_r_valid) begin
      seen[0]++;
      if (exp_q0.size() == 0) check(1'b0, "R3/R9 unexpected valid lane R", {15'd0, rx_r_len16, rx_r_word}, 0);
      else begin
        logic [16:0] e;
        e = exp_q0.pop_front();
        check({rx_r_len16, rx_r_word} == e, "R1/R2 lane R word", {15'd0, rx_r_len16, rx_r_word}, {15'd0, e});
        check(age[0] == 3, "R8 lane R latency", age[0], 3);
      end
    end
    if (rx_s_valid) begin
      seen[1]++;
      if (exp_q1.size() == 0) check(1'b0, "R3/R9 unexpected valid lane S", {15'd0, rx_s_len16, rx_s_word}, 0);
      else begin
        logic [16:0] e;
        e = exp_q1.pop_front();
        check({rx_s_len16, rx_s_word} == e, "R1/R2 lane S word", {15'd0, rx_s_len16, rx_s_word}, {15'd0, e});
        check(age[1] == 3, "R8 lane S latency", age[1], 3);
      end
    end
  end

  // driver: one window on a lane; pushes the expected receive item
  task automatic run_win(input int ch, input int nbits, input logic [15:0] din, output logic [15:0] got);
    got = '0;
    @(negedge mclk);
    repeat (3) @(negedge mclk);
    check((ch == 0 ? rout : sout) == 1'b0, "R7 idle before window", ch == 0 ? rout : sout, 0);
    if (nbits == 8)
      if (ch == 0) exp_q0.push_back({1'b0, 8'h00, line_code(din[7:0], g711_sel, alaw_sel)});
      else         exp_q1.push_back({1'b0, 8'h00, line_code(din[7:0], g711_sel, alaw_sel)});
    else if (nbits == 16)
      if (ch == 0) exp_q0.push_back({1'b1, din});
      else         exp_q1.push_back({1'b1, din});
    if (ch == 0) ena_r = 1'b1; else ena_s = 1'b1;
    #100;
    for (int i = 0; i < nbits; i++) begin
      bclk = 1'b1;
      if (ch == 0) rin = din[nbits-1-i]; else sin = din[nbits-1-i];
      #BHALF;
      got = {got[14:0], (ch == 0 ? rout : sout)};
      bclk = 1'b0;
      #BHALF;
    end
    #100;
    if (ch == 0) ena_r = 1'b0; else ena_s = 1'b0;
    age[ch] = 0;
    #50;
    check((ch == 0 ? rout : sout) == 1'b0, "R7 idle after window", ch == 0 ? rout : sout, 0);
    repeat (8) @(negedge mclk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    logic [15:0] got;
    int s0;
    age[0] = 0; age[1] = 0; seen[0] = 0; seen[1] = 0;
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;
    @(negedge mclk);
    // R10 reset state
    check({rx_r_valid, rx_s_valid, rx_r_len16, rx_s_len16, ferr_r, ferr_s, rout, sout} == 8'h00,
          "R10 reset flags", {rx_r_valid, rx_s_valid, rx_r_len16, rx_s_len16, ferr_r, ferr_s, rout, sout}, 0);
    check(rx_r_word == 0 && rx_s_word == 0, "R10 reset words", {rx_r_word, rx_s_word}, 0);

    // R1 R6: plain sign-magnitude codes
    tx_r_word = 16'h00C3;
    run_win(0, 8, 16'h00A5, got);
    check(got[7:0] == 8'hC3, "R6 tx 8-bit plain", got[7:0], 8'hC3);

    // R4 mu-law: line +zero 0xFF is internal 0x80
    g711_sel = 1'b1; alaw_sel = 1'b0; tx_r_word = 16'h0080;
    run_win(0, 8, 16'h00FF, got);
    check(got[7:0] == 8'hFF, "R4 mu-law tx +zero", got[7:0], 8'hFF);

    // R4 A-law: internal +full scale 0xFF is 0xAA on the line
    alaw_sel = 1'b1; tx_r_word = 16'h00FF;
    run_win(0, 8, 16'h00D5, got);
    check(got[7:0] == 8'hAA, "R4 A-law tx +full scale", got[7:0], 8'hAA);

    // R6: companded word over a 16-cycle window is followed by zeros
    alaw_sel = 1'b0; tx_s_word = 16'h0000;
    run_win(1, 16, 16'h7FFE, got);
    check(got == 16'h7F00, "R6 tx code then zeros", got, 16'h7F00);

    // R2 R5 R9: linear on lane S with G.711 on; lane R stays quiet
    s0 = seen[0];
    tx_lin = 1'b1; tx_s_word = 16'h1234; alaw_sel = 1'b1;
    run_win(1, 16, 16'h8001, got);
    check(got == 16'h1234, "R5/R6 tx linear unchanged", got, 16'h1234);
    check(seen[0] == s0, "R9 no lane R valid from lane S", seen[0], s0);

    // R3: bad length, then sticky through a good window
    s0 = seen[0];
    run_win(0, 12, 16'h0ABC, got);
    check(seen[0] == s0, "R3 no valid on bad window", seen[0], s0);
    check(ferr_r == 1'b1, "R3 error set", ferr_r, 1);
    check(ferr_s == 1'b0, "R9 other lane error clear", ferr_s, 0);
    tx_r_word = 16'hBEEF;
    run_win(0, 16, 16'h5A5A, got);
    check(got == 16'hBEEF, "R6 tx linear lane R", got, 16'hBEEF);
    check(ferr_r == 1'b1, "R3 error sticky", ferr_r, 1);

    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R1/R2 all words delivered",
          exp_q0.size() + exp_q1.size(), 0);
    finish_up();
  end
endmodule